// File: doc/BRIEF.md
# Asynchronous Parallel Memory Controller

This block sits between a synchronous host and an asynchronous, SRAM-style, 16-bit non-volatile memory. The host presents one request at a time on a valid/ready port. A request carries a direction, a word address, write data and a two-bit lane mask. The controller turns each request into a strobe sequence on the memory pins: active-low chip select, output enable, write enable and two lane enables, an address bus and a split data bus. The data bus has an output value, an output enable and an input value, and the pad ring joins them into a tristate bus.

Every analog limit is given in nanoseconds. The controller converts each limit to clock cycles by ceiling division against the clock period parameter, and a grade parameter selects the fast or slow limit set. The controller also gates all traffic behind a settle wait after supply-valid is reported, and it blocks new accesses while a brownout-inhibit input is high. The full wait starts again once the inhibit clears.

Top module: `pmem_ctrl`

## Requirements
- R1: A write drives chip select and write enable low while output enable stays high. The controller drives the data bus only while write enable is low.
- R2: A read drives chip select and output enable low while write enable stays high. Every accepted request ends with `rsp_valid` high for exactly one cycle while chip select is high. For a read, `rsp_rdata` then holds the captured word; for a write it is zero.
- R3: In `req_mask`, bit 1 selects data bits 15:8 and drives `mem_ub_n` low, and bit 0 selects bits 7:0 and drives `mem_lb_n` low. A write changes only the selected lanes of the addressed word. A read returns zero in every lane it did not select.
- R4: A request with mask 00 is accepted, produces no chip-select pulse, and returns `rsp_valid` in the cycle after acceptance with zero data.
- R5: Write enable stays low for at least max(ceil(pulse/T), ceil(address-to-end/T)) cycles. On the fast grade the pulse limit is 15 ns and the address-to-end limit is 18 ns; on the slow grade they are 25 ns and 28 ns. Write data is driven for at least ceil(10 ns/T) (fast) or ceil(15 ns/T) (slow) cycles before write enable rises. The data drive is released in the same cycle in which write enable rises.
- R6: The address is stable while chip select is low, and for ceil(12 ns/T) cycles after write enable rises. Two falling edges of chip select are at least ceil(35 ns/T) (fast) or ceil(45 ns/T) (slow) cycles apart.
- R7: Read data is captured only after chip select has been low for max(ceil(35/T), ceil(15/T)) cycles on the fast grade, or max(ceil(45/T), ceil(25/T)) cycles on the slow grade.
- R8: For a write that follows a read, the controller does not drive the data bus during the first ceil(12 ns/T) (fast) or ceil(15 ns/T) (slow) cycles of write enable low.
- R9: `req_ready` stays low until `pwr_ok` has been high, with `inhibit` low, for ceil(PWRUP_NS/T) consecutive cycles. Raising `inhibit` or dropping `pwr_ok` closes the gate at once and restarts the full wait.
- R10: A request that arrives while the gate is closed or an access is in progress is held off with `req_ready` low. It is carried out once the controller is ready and is never lost.
- R11: Each read holds chip select low for exactly the R7 cycle count; no cycles are added to or removed from the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply reported valid |
| inhibit | input | 1 | Brownout inhibit, blocks new accesses |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Data bus value seen from the memory |

## Verification
The bench's memory model returns a poison word until the access time has elapsed, so a controller that samples a read early captures garbage instead of stored data. The model also keeps driving the bus for the turnaround window after write enable falls whenever the previous access was a read. A controller that skips the turnaround gap is therefore flagged as contending, and one that releases data before write enable rises loses its write. Sweeps mix word writes, all three non-empty lane masks and the empty mask with interleaved reads. A design that decodes the mask the wrong way round, or strobes on an empty mask, returns wrong lanes or shows an extra chip-select edge. The power-up and inhibit cases count the cycles until ready. A gate that opens early, does not restart its wait, or drops a request that was held off shows up as a wrong count or as data missing from the word read back.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int LANES = 2;

    typedef enum logic {
        GRADE_FAST = 1'b0,
        GRADE_SLOW = 1'b1
    } grade_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_RECOVER
    } st_e;

    typedef struct packed {
        logic wr;
        logic up;
        logic lo;
    } op_t;

    // Limits already converted to clock cycles.
    typedef struct packed {
        int unsigned rd_len;   // read strobe before capture
        int unsigned wr_min;   // write pulse / address-to-end
        int unsigned dv_len;   // data valid before end of write
        int unsigned rec_len;  // address hold after write
        int unsigned cyc_len;  // strobe-to-strobe spacing
        int unsigned hiz_len;  // bus release after write strobe
    } tim_t;

    function automatic int unsigned cdiv(int unsigned ns, int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic tim_t grade_cycles(grade_e g, int unsigned per);
        tim_t t;
        if (g == GRADE_FAST) begin
            t.rd_len  = umax(cdiv(35, per), cdiv(15, per));
            t.wr_min  = umax(cdiv(15, per), cdiv(18, per));
            t.dv_len  = cdiv(10, per);
            t.rec_len = cdiv(12, per);
            t.cyc_len = cdiv(35, per);
            t.hiz_len = cdiv(12, per);
        end else begin
            t.rd_len  = umax(cdiv(45, per), cdiv(25, per));
            t.wr_min  = umax(cdiv(25, per), cdiv(28, per));
            t.dv_len  = cdiv(15, per);
            t.rec_len = cdiv(12, per);
            t.cyc_len = cdiv(45, per);
            t.hiz_len = cdiv(15, per);
        end
        return t;
    endfunction

endpackage

// File: rtl/pmc_pwr_gate.sv
module pmc_pwr_gate #(
    parameter int unsigned WAIT_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic inhibit,
    output logic open
);
    localparam int unsigned WAIT_EFF = (WAIT_CYC < 1) ? 1 : WAIT_CYC;
    localparam int CW = $clog2(WAIT_EFF + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok || inhibit) begin
            cnt <= '0;
        end else if (cnt != CW'(WAIT_EFF)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign open = (cnt == CW'(WAIT_EFF)) && pwr_ok && !inhibit;

    AST_WAIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> !open); // R9

endmodule

// File: rtl/pmc_lanes.sv
module pmc_lanes
    import pmc_pkg::*;
(
    input  logic        strobe,
    input  op_t         op,
    input  logic [15:0] dq_in,
    output logic        ub_n,
    output logic        lb_n,
    output logic [15:0] rd_word
);
    logic [LANES-1:0] sel;
    assign sel = {op.up, op.lo};

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign rd_word[8*b +: 8] = sel[b] ? dq_in[8*b +: 8] : 8'h00;
    end

    assign ub_n = !(strobe && sel[1]);
    assign lb_n = !(strobe && sel[0]);

endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int     ADDR_W = 21,
    parameter grade_e GRADE  = GRADE_FAST,
    parameter int     CLK_NS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    input  logic [15:0]       lane_rd,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              strobe,
    output op_t               op_q,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe
);
    localparam tim_t        TIM    = grade_cycles(GRADE, unsigned'(CLK_NS));
    localparam int unsigned RD_LEN = TIM.rd_len;
    localparam int unsigned WR_MIN = TIM.wr_min;
    localparam int unsigned DV     = TIM.dv_len;
    localparam int unsigned REC    = TIM.rec_len;
    localparam int unsigned CYC    = TIM.cyc_len;
    localparam int unsigned HIZ    = TIM.hiz_len;
    localparam int unsigned LONGEST = umax(RD_LEN, umax(WR_MIN, HIZ + DV)) + umax(REC, CYC);
    localparam int          CW     = $clog2(LONGEST + 1);

    st_e           st;
    logic [CW-1:0] cnt, len_q, rec_q, hz_q, wl_run;
    logic [CW-1:0] len_n, rec_n, hz_n;
    logic          after_rd;
    logic          take;
    int unsigned   len_i, rec_i;

    assign req_ready = open && (st == ST_IDLE);
    assign take      = req_valid && req_ready;

    // Per-access lengths: the turnaround gap only follows a read.
    always_comb begin
        len_i = req_write ? umax(WR_MIN, (after_rd ? HIZ : 32'd0) + DV) : RD_LEN;
        rec_i = umax(req_write ? REC : 32'd0, (CYC > len_i) ? CYC - len_i : 32'd0);
        len_n = CW'(len_i);
        rec_n = CW'(rec_i);
        hz_n  = after_rd ? CW'(HIZ) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            len_q      <= '0;
            rec_q      <= '0;
            hz_q       <= '0;
            op_q       <= '0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            after_rd   <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (take) begin
                        if (req_mask == 2'b00) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= '0;
                        end else begin
                            st         <= ST_STROBE;
                            cnt        <= '0;
                            len_q      <= len_n;
                            rec_q      <= rec_n;
                            hz_q       <= hz_n;
                            op_q       <= '{wr: req_write, up: req_mask[1], lo: req_mask[0]};
                            mem_addr   <= req_addr;
                            mem_dq_out <= req_wdata;
                        end
                    end
                end
                ST_STROBE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == len_q - 1'b1) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= op_q.wr ? 16'h0000 : lane_rd;
                        after_rd  <= !op_q.wr;
                        cnt       <= '0;
                        st        <= (rec_q == '0) ? ST_IDLE : ST_RECOVER;
                    end
                end
                ST_RECOVER: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == rec_q - 1'b1) begin
                        cnt <= '0;
                        st  <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign strobe    = (st == ST_STROBE);
    assign mem_ce_n  = !strobe;
    assign mem_we_n  = !(strobe && op_q.wr);
    assign mem_oe_n  = !(strobe && !op_q.wr);
    assign mem_dq_oe = strobe && op_q.wr && (cnt >= hz_q);

    // Length of the current write-enable low run, kept for the pulse check.
    always_ff @(posedge clk) begin
        if (rst) wl_run <= '0;
        else     wl_run <= mem_we_n ? '0 : wl_run + 1'b1;
    end

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R6
    AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_dq_oe); // R5
    AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (wl_run >= CW'(WR_MIN))); // R5
    AST_RSP_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> mem_ce_n); // R2

endmodule

// File: rtl/pmem_ctrl.sv
module pmem_ctrl
    import pmc_pkg::*;
#(
    parameter int     ADDR_W   = 21,
    parameter grade_e GRADE    = GRADE_FAST,
    parameter int     CLK_NS   = 10,
    parameter int     PWRUP_NS = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic              inhibit,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    localparam int unsigned PU_CYC = cdiv(unsigned'(PWRUP_NS), unsigned'(CLK_NS));

    logic        gate_open;
    logic        strobe;
    op_t         op_q;
    logic [15:0] lane_rd;

    pmc_pwr_gate #(.WAIT_CYC(PU_CYC)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .pwr_ok  (pwr_ok),
        .inhibit (inhibit),
        .open    (gate_open)
    );

    pmc_seq #(.ADDR_W(ADDR_W), .GRADE(GRADE), .CLK_NS(CLK_NS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .open       (gate_open),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .lane_rd    (lane_rd),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .strobe     (strobe),
        .op_q       (op_q),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    pmc_lanes u_lanes (
        .strobe  (strobe),
        .op      (op_q),
        .dq_in   (mem_dq_in),
        .ub_n    (mem_ub_n),
        .lb_n    (mem_lb_n),
        .rd_word (lane_rd)
    );

    AST_GATED_START: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n) |-> $past(gate_open)); // R9

endmodule

// File: tb/tb_pmem_ctrl.sv
module tb_pmem_ctrl;
    import pmc_pkg::*;

    localparam int CLK_NS = 10;
    localparam int AW     = 6;
    localparam int PU_NS  = 500;
    localparam int PU_C   = (PU_NS + CLK_NS - 1) / CLK_NS;
    localparam int WP_C   = ((15 + CLK_NS - 1) / CLK_NS > (18 + CLK_NS - 1) / CLK_NS) ?
                            (15 + CLK_NS - 1) / CLK_NS : (18 + CLK_NS - 1) / CLK_NS;
    localparam int DV_C   = (10 + CLK_NS - 1) / CLK_NS;
    localparam int REC_C  = (12 + CLK_NS - 1) / CLK_NS;
    localparam int CYC_C  = (35 + CLK_NS - 1) / CLK_NS;
    localparam int RD_C   = ((35 + CLK_NS - 1) / CLK_NS > (15 + CLK_NS - 1) / CLK_NS) ?
                            (35 + CLK_NS - 1) / CLK_NS : (15 + CLK_NS - 1) / CLK_NS;
    localparam int HIZ_C  = (12 + CLK_NS - 1) / CLK_NS;
    localparam int TAIL_C = (10 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0, inhibit = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_mask = 2'b00;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] dq_model = 16'hDEAD;

    int n_checks = 0;
    int n_fail   = 0;
    int ce_falls = 0;

    always #(CLK_NS / 2) clk = ~clk;

    pmem_ctrl #(.ADDR_W(AW), .GRADE(GRADE_FAST), .CLK_NS(CLK_NS), .PWRUP_NS(PU_NS)) dut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .inhibit(inhibit),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_model)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] f_word(int a);
        return 16'(a * 1237 + 16'h01C3);
    endfunction
    function automatic logic [15:0] g_word(int a);
        return 16'(a * 311 + 16'h7E00);
    endfunction
    function automatic logic [1:0] wmask(int a);
        return (a % 3 == 0) ? 2'b10 : (a % 3 == 1) ? 2'b01 : 2'b00;
    endfunction
    function automatic logic [15:0] after_bytes(int a);
        logic [1:0] m = wmask(a);
        return {m[1] ? g_word(a)[15:8] : f_word(a)[15:8], m[0] ? g_word(a)[7:0] : f_word(a)[7:0]};
    endfunction

    // Behavioural memory with lane enables and bus timing checks.
    logic [15:0] mem [1 << AW];
    int rd_run = 0, tail = 0, we_run = 0, drv_run = 0, undrv_run = 0, hold_left = 0, ce_gap = 0;
    logic any_drv = 1'b0, rd_recent = 1'b0, seen_fall = 1'b0, prev_ce_n = 1'b1;
    logic ub_l = 1'b1, lb_l = 1'b1;
    logic [15:0] wd_l = '0;
    logic [AW-1:0] addr_l = '0, hold_addr = '0;

    always @(negedge clk) begin
        if (rst) begin
            rd_run = 0; tail = 0; we_run = 0; drv_run = 0; undrv_run = 0; hold_left = 0;
            any_drv = 1'b0; rd_recent = 1'b0; seen_fall = 1'b0; prev_ce_n = 1'b1;
            dq_model = 16'hDEAD;
        end else begin
            logic reading, wlow, mem_drv;
            reading = !mem_ce_n && !mem_oe_n && mem_we_n;
            wlow    = !mem_ce_n && !mem_we_n;
            ce_gap++;
            if (prev_ce_n && !mem_ce_n) begin
                ce_falls++;
                if (seen_fall) check(ce_gap >= CYC_C, "R6 strobe spacing", ce_gap, CYC_C);
                seen_fall = 1'b1;
                ce_gap = 0;
            end
            prev_ce_n = mem_ce_n;
            if (reading) begin
                rd_run++;
            end else if (rd_run > 0) begin
                check(rd_run == RD_C, "R11 R7 read strobe length", rd_run, RD_C);
                rd_run = 0; tail = TAIL_C; rd_recent = 1'b1;
            end else if (tail > 0) begin
                tail--;
            end
            if (reading && rd_run >= RD_C)
                dq_model = {mem_ub_n ? 8'h5A : mem[mem_addr][15:8],
                            mem_lb_n ? 8'hA5 : mem[mem_addr][7:0]};
            else
                dq_model = 16'hDEAD;
            if (wlow) begin
                we_run++;
                check(mem_oe_n, "R1 output enable high in write", mem_oe_n, 1);
                if (mem_dq_oe) begin drv_run++; any_drv = 1'b1; wd_l = mem_dq_out; end
                else begin drv_run = 0; if (!any_drv) undrv_run++; end
                ub_l = mem_ub_n; lb_l = mem_lb_n; addr_l = mem_addr;
            end else if (we_run > 0) begin
                check(we_run >= WP_C, "R5 write pulse width", we_run, WP_C);
                check(drv_run >= DV_C, "R5 data before write end", drv_run, DV_C);
                check(!mem_dq_oe, "R5 drive released with write end", mem_dq_oe, 0);
                if (rd_recent) check(undrv_run >= HIZ_C, "R8 turnaround gap", undrv_run, HIZ_C);
                if (!ub_l) mem[addr_l][15:8] = wd_l[15:8];
                if (!lb_l) mem[addr_l][7:0]  = wd_l[7:0];
                hold_left = REC_C; hold_addr = addr_l; rd_recent = 1'b0;
                we_run = 0; drv_run = 0; undrv_run = 0; any_drv = 1'b0;
            end else if (mem_dq_oe) begin
                check(1'b0, "R1 drive without write enable", mem_dq_oe, 0);
            end
            if (hold_left > 0) begin
                check(mem_addr == hold_addr, "R6 address hold after write", mem_addr, hold_addr);
                hold_left--;
            end
            mem_drv = reading || tail > 0 || (rd_recent && wlow && we_run <= HIZ_C);
            if (mem_drv && mem_dq_oe) check(1'b0, "R8 bus contention", 1, 0);
        end
    end

    task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
        @(negedge clk);
        check(!rsp_valid, "R2 response pulse width", rsp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int k, falls0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle strobes after reset",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        check(!req_ready && !rsp_valid, "R9 not ready before power", req_ready, 0);

        // R9: power-up wait
        pwr_ok = 1'b1;
        for (int i = 1; i <= PU_C; i++) begin
            @(negedge clk);
            if (i == PU_C - 1) check(!req_ready, "R9 ready one cycle early", req_ready, 0);
            if (i == PU_C)     check(req_ready, "R9 ready after wait", req_ready, 1);
        end

        // R1 R3: word writes
        for (int a = 0; a < (1 << AW); a++) do_req(1'b1, AW'(a), f_word(a), 2'b11, rd);
        // R2 R7: word reads
        for (int a = 0; a < (1 << AW); a++) begin
            do_req(1'b0, AW'(a), 16'h0, 2'b11, rd);
            check(rd == f_word(a), "R2 R7 word read", rd, f_word(a));
        end
        // R3 R4 R8: read followed by a lane write
        for (int a = 0; a < (1 << AW); a++) begin
            do_req(1'b0, AW'(a), 16'h0, 2'b11, rd);
            check(rd == f_word(a), "R8 read before turnaround", rd, f_word(a));
            falls0 = ce_falls;
            do_req(1'b1, AW'(a), g_word(a), wmask(a), rd);
            if (wmask(a) == 2'b00)
                check(ce_falls == falls0 && rd == 16'h0, "R4 empty write no strobe", ce_falls - falls0, 0);
        end
        // R3 R4: lane reads
        for (int a = 0; a < (1 << AW); a++) begin
            logic [1:0] m;
            logic [15:0] e;
            m = (a % 4 == 0) ? 2'b11 : (a % 4 == 1) ? 2'b10 : (a % 4 == 2) ? 2'b01 : 2'b00;
            e = after_bytes(a) & {{8{m[1]}}, {8{m[0]}}};
            falls0 = ce_falls;
            do_req(1'b0, AW'(a), 16'h0, m, rd);
            check(rd == e, "R3 lane read", rd, e);
            if (m == 2'b00) check(ce_falls == falls0, "R4 empty read no strobe", ce_falls - falls0, 0);
        end

        // R9 R10: inhibit holds a request, then the full wait restarts
        @(negedge clk);
        inhibit = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(5); req_wdata = 16'hC3C3; req_mask = 2'b11;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!req_ready && mem_ce_n, "R10 held off under inhibit", {req_ready, mem_ce_n}, 2'b01);
        end
        inhibit = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (!req_ready);
        check(k == PU_C, "R9 wait restarts after inhibit", k, PU_C);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        do_req(1'b0, AW'(5), 16'h0, 2'b11, rd);
        check(rd == 16'hC3C3, "R10 held request not lost", rd, 16'hC3C3);

        // R9: supply loss closes the gate at once
        @(negedge clk);
        pwr_ok = 1'b0;
        @(negedge clk);
        check(!req_ready, "R9 gate closes on supply loss", req_ready, 0);
        pwr_ok = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!req_ready);
        check(k == PU_C, "R9 wait restarts after supply loss", k, PU_C);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule